// File: doc/BRIEF.md
# Priority Address Decoder with Aliasing

This block routes every access on a 48-bit system bus to one downstream target: main RAM, the 32-bit PCI space, video RAM, the MMIO register bank, or nothing. With the target it returns the address as that target sees it. The system map is a set of windows. Where windows overlap, the one with the higher priority wins. Alias windows move an address into another space by removing their own base and adding a destination offset. Addresses that enter the PCI space are decoded again by a nested stage. That stage holds a video area container with two 32 KiB banks and the two device windows.

A single control input turns the legacy video window on or off. When the window is off, the RAM underneath it becomes visible. A request is an address qualified by a valid strobe. The result is registered and appears one clock later as a target code, a translated address and a hit flag.

Top module: `sysbus_window_router`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. When `req_valid` is low, `rsp_target`, `rsp_addr` and `rsp_hit` keep their previous values.
- R2: A system address from 0x0 to 0xDFFFFFFF that the video window does not claim goes to RAM (target code 1). The translated address equals the system address.
- R3: A system address from 0x1_0000_0000 to 0x1_1FFF_FFFF goes to RAM with translated address (address − 0x1_0000_0000 + 0xE0000000).
- R4: With `vga_win_en` high, the video window 0xA0000–0xBFFFF takes precedence over RAM and forwards to PCI space at the same address. PCI 0xA0000–0xA7FFF goes to video RAM (code 3) at 0x10000 + (address − 0xA0000). PCI 0xA8000–0xAFFFF goes to video RAM at 0x20000 + (address − 0xA8000). PCI 0xB0000–0xBFFFF, which no bank claims, goes to PCI (code 2) with the address unchanged.
- R5: With `vga_win_en` low, addresses 0xA0000–0xBFFFF go to RAM with the address unchanged.
- R6: Addresses 0xE0000000–0xFFFFFFFF forward to PCI space unchanged. PCI 0xE1000000–0xE1FFFFFF goes to video RAM at (address − 0xE1000000). PCI 0xE2000000–0xE200FFFF goes to MMIO (code 4) at (address − 0xE2000000). Any other address in this range goes to PCI (code 2) with the address unchanged.
- R7: Addresses at or above 0x1_2000_0000 are claimed by no window. The result is target code 0, translated address 0 and `rsp_hit` low.
- R8: `rsp_hit` is high exactly when the registered target code is not 0 (none).
- R9: `vga_win_en` is sampled in the request cycle only. Changing it while no request is presented leaves the held result unchanged.
- R10: While reset is asserted, `rsp_valid` and `rsp_hit` are low, `rsp_target` is 0 and `rsp_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 48 | System bus address |
| vga_win_en | input | 1 | Legacy video window enable |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_target | output | 3 | Target code: 0 none, 1 RAM, 2 PCI, 3 video RAM, 4 MMIO |
| rsp_addr | output | 48 | Address translated into the target's space |
| rsp_hit | output | 1 | High when some window claimed the address |

## Verification
Every result is due exactly one clock edge after the request that carried it. There is one register between `req_addr`/`vga_win_en` and the outputs, and the enable is taken on that same edge. The bench drives inputs after a falling edge and compares the outputs at the next falling edge against a model updated for the request that edge captured. Idle cycles and enable changes between requests are compared the same way, so the held values are checked one cycle after each non-request.

// File: rtl/swr_pkg.sv
package swr_pkg;

  localparam int SYS_AW  = 48;
  localparam int PCI_AW  = 32;
  localparam int NUM_WIN = 4;
  localparam int PRIO_W  = 2;

  // window indices at system level
  localparam int WIN_LORAM = 0;
  localparam int WIN_HIRAM = 1;
  localparam int WIN_VIDEO = 2;
  localparam int WIN_HOLE  = 3;

  // windows whose destination is the PCI space rather than RAM
  localparam logic [NUM_WIN-1:0] FWD_PCI_MASK = 4'b1100;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_PCI  = 3'd2,
    TGT_VRAM = 3'd3,
    TGT_MMIO = 3'd4
  } tgt_e;

  function automatic logic [SYS_AW-1:0] win_base(int i);
    case (i)
      WIN_LORAM: win_base = 48'h0000_0000_0000;
      WIN_HIRAM: win_base = 48'h0001_0000_0000;
      WIN_VIDEO: win_base = 48'h0000_000A_0000;
      default:   win_base = 48'h0000_E000_0000;
    endcase
  endfunction

  function automatic logic [SYS_AW-1:0] win_limit(int i);
    case (i)
      WIN_LORAM: win_limit = 48'h0000_DFFF_FFFF;
      WIN_HIRAM: win_limit = 48'h0001_1FFF_FFFF;
      WIN_VIDEO: win_limit = 48'h0000_000B_FFFF;
      default:   win_limit = 48'h0000_FFFF_FFFF;
    endcase
  endfunction

  // offset added after the window base is removed
  function automatic logic [SYS_AW-1:0] win_dest(int i);
    case (i)
      WIN_LORAM: win_dest = 48'h0000_0000_0000;
      WIN_HIRAM: win_dest = 48'h0000_E000_0000;
      WIN_VIDEO: win_dest = 48'h0000_000A_0000;
      default:   win_dest = 48'h0000_E000_0000;
    endcase
  endfunction

  function automatic logic [PRIO_W-1:0] win_prio(int i);
    win_prio = (i == WIN_VIDEO) ? 2'd1 : 2'd0;
  endfunction

  // PCI-space layout
  localparam logic [PCI_AW-1:0] VAREA_BASE  = 32'h000A_0000;
  localparam logic [PCI_AW-1:0] VAREA_LIMIT = 32'h000B_FFFF;
  localparam int                NUM_BANKS   = 2;
  localparam int                BANK_SPAN   = 32'h8000;
  localparam int                BANK_STRIDE = 32'h1_0000;
  localparam logic [PCI_AW-1:0] VBAR_BASE   = 32'hE100_0000;
  localparam logic [PCI_AW-1:0] VBAR_LIMIT  = 32'hE1FF_FFFF;
  localparam logic [PCI_AW-1:0] MMIO_BASE   = 32'hE200_0000;
  localparam logic [PCI_AW-1:0] MMIO_LIMIT  = 32'hE200_FFFF;

endpackage

// File: rtl/swr_window.sv
// One address window: removes its base, checks the span, adds its destination.
module swr_window #(
  parameter int             AW    = 48,
  parameter logic [AW-1:0]  BASE  = '0,
  parameter logic [AW-1:0]  LIMIT = '1,
  parameter logic [AW-1:0]  DEST  = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] SPAN = LIMIT - BASE;

  logic [AW-1:0] off;

  always_comb begin
    off    = addr_i - BASE;
    hit_o  = (off <= SPAN);
    addr_o = off + DEST;
  end
endmodule

// File: rtl/swr_prio_pick.sv
// Selects the highest-priority hitting window; ties go to the lowest index.
module swr_prio_pick #(
  parameter int N  = 4,
  parameter int PW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    hit_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            found_o,
  output logic [IW-1:0]   sel_o
);
  logic [PW-1:0] best;

  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && (!found_o || prio_i[i*PW +: PW] > best)) begin
        found_o = 1'b1;
        sel_o   = IW'(i);
        best    = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/swr_pci_decode.sv
// Second-level decode inside the 32-bit PCI space.
module swr_pci_decode
  import swr_pkg::*;
#(
  parameter int PW = PCI_AW
) (
  input  logic [PW-1:0] pci_addr_i,
  output tgt_e          tgt_o,
  output logic [PW-1:0] dev_addr_o
);
  logic                 area_hit;
  logic [PW-1:0]        area_off;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [PW-1:0]        bank_addr [NUM_BANKS];
  logic                 vbar_hit, mmio_hit;
  logic [PW-1:0]        vbar_addr, mmio_addr;

  // video area container: rebases to its own offset
  swr_window #(.AW(PW), .BASE(VAREA_BASE), .LIMIT(VAREA_LIMIT), .DEST('0)) u_area (
    .addr_i(pci_addr_i), .hit_o(area_hit), .addr_o(area_off)
  );

  // banks inside the container, each an alias onto video RAM
  for (genvar j = 0; j < NUM_BANKS; j++) begin : g_bank
    swr_window #(
      .AW(PW),
      .BASE (PW'(j * BANK_SPAN)),
      .LIMIT(PW'(j * BANK_SPAN + BANK_SPAN - 1)),
      .DEST (PW'((j + 1) * BANK_STRIDE))
    ) u_bank (
      .addr_i(area_off), .hit_o(bank_hit[j]), .addr_o(bank_addr[j])
    );
  end

  swr_window #(.AW(PW), .BASE(VBAR_BASE), .LIMIT(VBAR_LIMIT), .DEST('0)) u_vbar (
    .addr_i(pci_addr_i), .hit_o(vbar_hit), .addr_o(vbar_addr)
  );

  swr_window #(.AW(PW), .BASE(MMIO_BASE), .LIMIT(MMIO_LIMIT), .DEST('0)) u_mmio (
    .addr_i(pci_addr_i), .hit_o(mmio_hit), .addr_o(mmio_addr)
  );

  always_comb begin
    tgt_o      = TGT_PCI;
    dev_addr_o = pci_addr_i;
    if (vbar_hit) begin
      tgt_o      = TGT_VRAM;
      dev_addr_o = vbar_addr;
    end else if (mmio_hit) begin
      tgt_o      = TGT_MMIO;
      dev_addr_o = mmio_addr;
    end else if (area_hit) begin
      for (int j = 0; j < NUM_BANKS; j++) begin
        if (bank_hit[j]) begin
          tgt_o      = TGT_VRAM;
          dev_addr_o = bank_addr[j];
        end
      end
    end
  end
endmodule

// File: rtl/sysbus_window_router.sv
module sysbus_window_router
  import swr_pkg::*;
#(
  parameter int ADDR_W = SYS_AW,
  parameter int PCI_W  = PCI_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              vga_win_en,
  output logic              rsp_valid,
  output logic [2:0]        rsp_target,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_hit
);
  localparam int IDX_W = $clog2(NUM_WIN);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // system-level windows
  logic [NUM_WIN-1:0]        raw_hit, win_hit;
  logic [ADDR_W-1:0]         win_addr [NUM_WIN];
  logic [NUM_WIN*PRIO_W-1:0] prio_flat;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    swr_window #(
      .AW(ADDR_W),
      .BASE (ADDR_W'(win_base(i))),
      .LIMIT(ADDR_W'(win_limit(i))),
      .DEST (ADDR_W'(win_dest(i)))
    ) u_win (
      .addr_i(req_addr), .hit_o(raw_hit[i]), .addr_o(win_addr[i])
    );
    assign prio_flat[i*PRIO_W +: PRIO_W] = win_prio(i);
    if (i == WIN_VIDEO) begin : g_gated
      assign win_hit[i] = raw_hit[i] & vga_win_en;
    end else begin : g_open
      assign win_hit[i] = raw_hit[i];
    end
  end

  logic             found;
  logic [IDX_W-1:0] sel;

  swr_prio_pick #(.N(NUM_WIN), .PW(PRIO_W)) u_pick (
    .hit_i(win_hit), .prio_i(prio_flat), .found_o(found), .sel_o(sel)
  );

  logic [ADDR_W-1:0] sel_addr;
  tgt_e              pci_tgt;
  logic [PCI_W-1:0]  pci_dev_addr;

  assign sel_addr = win_addr[sel];

  swr_pci_decode #(.PW(PCI_W)) u_pci (
    .pci_addr_i(sel_addr[PCI_W-1:0]), .tgt_o(pci_tgt), .dev_addr_o(pci_dev_addr)
  );

  // next-state
  tgt_e              nxt_tgt;
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_hit;

  always_comb begin
    nxt_tgt  = TGT_NONE;
    nxt_addr = '0;
    nxt_hit  = found;
    if (found) begin
      if (FWD_PCI_MASK[sel]) begin
        nxt_tgt  = pci_tgt;
        nxt_addr = ADDR_W'(pci_dev_addr);
      end else begin
        nxt_tgt  = TGT_RAM;
        nxt_addr = sel_addr;
      end
    end
  end

  // registers
  logic              valid_q, hit_q;
  tgt_e              tgt_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      tgt_q   <= TGT_NONE;
      addr_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        tgt_q  <= nxt_tgt;
        addr_q <= nxt_addr;
        hit_q  <= nxt_hit;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_target = tgt_q;
  assign rsp_addr   = addr_q;
  assign rsp_hit    = hit_q;
endmodule

// File: rtl/swr_checker.sv
module swr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [47:0] req_addr,
  input logic        vga_win_en,
  input logic        rsp_valid,
  input logic [2:0]  rsp_target,
  input logic [47:0] rsp_addr,
  input logic        rsp_hit
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_target) && $stable(rsp_addr) && $stable(rsp_hit)));

  a_r2_low_ram_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < 48'hA_0000) |=> (rsp_target == 3'd1 && rsp_addr == $past(req_addr)));

  a_r3_high_ram_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= 48'h1_0000_0000 && req_addr <= 48'h1_1FFF_FFFF)
      |=> (rsp_target == 3'd1 && rsp_addr == $past(req_addr) - 48'h2000_0000));

  a_r4_bank0_reloc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vga_win_en && req_addr >= 48'hA_0000 && req_addr <= 48'hA_7FFF)
      |=> (rsp_target == 3'd3 && rsp_addr == $past(req_addr) - 48'h9_0000));

  a_r5_window_off_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vga_win_en && req_addr >= 48'hA_0000 && req_addr <= 48'hB_FFFF)
      |=> (rsp_target == 3'd1 && rsp_addr == $past(req_addr)));

  a_r7_unclaimed_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= 48'h1_2000_0000) |=> (!rsp_hit && rsp_target == 3'd0 && rsp_addr == 48'h0));
endmodule

bind sysbus_window_router swr_checker u_swr_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .vga_win_en(vga_win_en), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
  .rsp_addr(rsp_addr), .rsp_hit(rsp_hit)
);

// File: tb/sysbus_window_router_bench.sv
module sysbus_window_router_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [47:0] req_addr;
  logic        vga_win_en;
  logic        rsp_valid;
  logic [2:0]  rsp_target;
  logic [47:0] rsp_addr;
  logic        rsp_hit;

  int checks = 0;
  int errors = 0;

  // model state
  logic        m_valid = 1'b0;
  logic [2:0]  m_tgt   = 3'd0;
  logic [47:0] m_addr  = 48'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysbus_window_router u_sysbus_window_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .vga_win_en(vga_win_en), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
    .rsp_addr(rsp_addr), .rsp_hit(rsp_hit)
  );

  // behavioural map: returns {target, address}
  function automatic logic [50:0] ref_map(logic [47:0] a, logic en);
    logic [47:0] off;
    if (en && a >= 48'hA_0000 && a <= 48'hB_FFFF) begin
      off = a - 48'hA_0000;
      if (off < 48'h8000)       return {3'd3, 48'h1_0000 + off};
      else if (off < 48'h1_0000) return {3'd3, 48'h2_0000 + off - 48'h8000};
      else                       return {3'd2, a};
    end
    if (a <= 48'hDFFF_FFFF) return {3'd1, a};
    if (a <= 48'hFFFF_FFFF) begin
      if (a >= 48'hE100_0000 && a <= 48'hE1FF_FFFF) return {3'd3, a - 48'hE100_0000};
      if (a >= 48'hE200_0000 && a <= 48'hE200_FFFF) return {3'd4, a - 48'hE200_0000};
      return {3'd2, a};
    end
    if (a <= 48'h1_1FFF_FFFF) return {3'd1, a - 48'h2000_0000};
    return {3'd0, 48'h0};
  endfunction

  task automatic check(string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    check("R1", "rsp_valid", 48'(rsp_valid), 48'(m_valid));
    check(req, "rsp_target", 48'(rsp_target), 48'(m_tgt));
    check(req, "rsp_addr", rsp_addr, m_addr);
    check("R8", "rsp_hit", 48'(rsp_hit), 48'(m_tgt != 3'd0));
  endtask

  // called at a falling edge; result compared at the next falling edge
  task automatic step(logic v, logic [47:0] a, logic en, string req);
    logic [50:0] r;
    req_valid  = v;
    req_addr   = a;
    vga_win_en = en;
    @(posedge clk);
    m_valid = v;
    if (v) begin
      r      = ref_map(a, en);
      m_tgt  = r[50:48];
      m_addr = r[47:0];
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b1;
    req_addr   = 48'h1234;
    vga_win_en = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset values even with a request presented
    check("R10", "rsp_valid", 48'(rsp_valid), 48'h0);
    check("R10", "rsp_target", 48'(rsp_target), 48'h0);
    check("R10", "rsp_addr", rsp_addr, 48'h0);
    check("R10", "rsp_hit", 48'(rsp_hit), 48'h0);
    req_valid = 1'b0;
    rst_n     = 1'b1;
    repeat (3) @(negedge clk);

    // R2 low RAM identity
    step(1, 48'h0, 1, "R2");
    step(1, 48'h1234_5678, 1, "R2");
    step(1, 48'h9_FFFF, 1, "R2");
    step(1, 48'hC_0000, 1, "R2");
    step(1, 48'hDFFF_FFFF, 1, "R2");
    // R4 video window enabled: banks and unclaimed part of the area
    step(1, 48'hA_0000, 1, "R4");
    step(1, 48'hA_7FFF, 1, "R4");
    step(1, 48'hA_8000, 1, "R4");
    step(1, 48'hA_FFFF, 1, "R4");
    step(1, 48'hB_0000, 1, "R4");
    step(1, 48'hB_FFFF, 1, "R4");
    // R5 window disabled exposes RAM
    step(1, 48'hA_0000, 0, "R5");
    step(1, 48'hA_9ABC, 0, "R5");
    step(1, 48'hB_FFFF, 0, "R5");
    // R3 high RAM alias
    step(1, 48'h1_0000_0000, 1, "R3");
    step(1, 48'h1_1FFF_FFFF, 0, "R3");
    // R6 PCI hole and its devices
    step(1, 48'hE000_0000, 1, "R6");
    step(1, 48'hE100_0000, 1, "R6");
    step(1, 48'hE1FF_FFFF, 1, "R6");
    step(1, 48'hE200_0000, 1, "R6");
    step(1, 48'hE200_FFFF, 1, "R6");
    step(1, 48'hE201_0000, 1, "R6");
    step(1, 48'hFFFF_FFFF, 1, "R6");
    // R7 unclaimed
    step(1, 48'h1_2000_0000, 1, "R7");
    step(1, 48'hFFFF_FFFF_FFFF, 1, "R7");
    // R1 idle cycles hold the previous result
    step(1, 48'hE200_0010, 1, "R1");
    step(0, 48'h0000_0040, 1, "R1");
    step(0, 48'h1_2345_0000, 0, "R1");
    // R9 enable changes between requests have no effect on the held result
    step(1, 48'hA_0100, 1, "R9");
    step(0, 48'hA_0100, 0, "R9");
    step(0, 48'hA_0100, 1, "R9");
    step(1, 48'hA_0100, 0, "R9");
    // back-to-back mix
    step(1, 48'hA_8004, 1, "R4");
    step(1, 48'hA_8004, 0, "R5");
    step(1, 48'h5000, 1, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule